// File: doc/BRIEF.md
# Video Output Formatter with Cascaded Bus Enable

This block is the last stage of a video decoder. It takes decoded 8-bit luma samples and 8-bit Cb/Cr chroma samples, along with a pixel-valid strobe, and drives an 8-bit Y bus and an 8-bit C bus. The C bus carries one of two packings, selected by a static configuration input:

- **4:2:2**: Cb and Cr alternate on successive pixels.
- **4:1:1**: one Cb/Cr pair is spread, two bits per field, over the upper nibble of four successive pixels.

Chroma can be encoded as offset binary or as two's complement. When the upstream sync detector reports loss of lock, a fixed blue field can replace the picture. Luma and chroma each have their own phase control, which moves that path one clock earlier or one clock later than the sync outputs.

The block also decides whether this decoder may drive the shared output buses. Several decoders can hang on the same Y, C and sync wires, linked in a priority chain:

- A low priority input means a device higher in the chain owns the bus. All enables are then forced off.
- The priority output tells the devices further down to stay off the bus.

The tristate buffers themselves sit in the pad ring. This block only produces one enable per bus. All configuration inputs are static register values and change only while no pixels are flowing.

Top module: `vid_out_fmt`

## Requirements
- R1: After reset, y_out is 0x10, c_out is 0x80, and hs_out_n and vs_out_n are high.
- R2: With cfg_411=0, pixel k of a run (counting from 0) carries the Cb of its pair on C when k is even, and the Cr of that pair when k is odd. The pair's Cb and Cr are sampled at the even pixel.
- R3: With cfg_411=1, pixel slot s=k mod 4 carries C[7:6]=Cb[7-2s:6-2s] and C[5:4]=Cr[7-2s:6-2s] of its group, and C[3:0]=0 at all times.
- R4: With cfg_twos=1, the MSB of each Cb and Cr value is inverted before packing, and the blanking C value becomes 0x00. With cfg_twos=0, values pass unchanged.
- R5: With cfg_blue_en=1 and sync_lock=0, valid pixels output Y=0x29, Cb=0xF0 and Cr=0x6E (offset binary). With cfg_blue_en=0, video passes whatever the state of sync_lock.
- R6: The latency from a pixel at the inputs to y_out or c_out is 2 clocks when the path's phase code is 0 or 2, 1 clock when it is 1, and 3 clocks when it is 3. Luma and chroma are set independently.
- R7: While pix_vld is low, the formatter emits Y=0x10 and blank C (0x80, or 0x00 in two's complement).
- R8: hs_out_n and vs_out_n follow hs_in_n and vs_in_n two clocks later.
- R9: Each enable (y_oe, c_oe, hs_oe, vs_oe) is high exactly when oe_n is low, that bus's enable bit is set, and prio_in_n is high.
- R10: prio_out_n is low exactly when prio_in_n is low or at least one bus enable is high.
- R11: The pixel slot counter restarts at 0 at each run of pix_vld. Chroma inputs are sampled only on the first pixel of a pair (4:2:2) or group (4:1:1); their value on the other pixels is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_vld | input | 1 | Pixel strobe; high for each active pixel |
| y_in | input | 8 | Decoded luma sample |
| cb_in | input | 8 | Decoded Cb sample, offset binary |
| cr_in | input | 8 | Decoded Cr sample, offset binary |
| hs_in_n | input | 1 | Horizontal sync from sync generator, active low |
| vs_in_n | input | 1 | Vertical sync from sync generator, active low |
| sync_lock | input | 1 | High when horizontal sync is locked |
| cfg_411 | input | 1 | 1 selects 4:1:1 packing, 0 selects 4:2:2 |
| cfg_twos | input | 1 | 1 selects two's-complement chroma |
| cfg_blue_en | input | 1 | Enables blue field on loss of lock |
| y_phase | input | 2 | Luma phase code (0 normal, 1 early, 2 normal, 3 late) |
| c_phase | input | 2 | Chroma phase code, same coding |
| en_y | input | 1 | Register enable for the Y bus |
| en_c | input | 1 | Register enable for the C bus |
| en_hs | input | 1 | Register enable for the horizontal sync output |
| en_vs | input | 1 | Register enable for the vertical sync output |
| oe_n | input | 1 | Output-enable pin, active low |
| prio_in_n | input | 1 | Priority from higher device; low means bus taken |
| y_out | output | 8 | Luma output bus |
| c_out | output | 8 | Chroma output bus |
| hs_out_n | output | 1 | Delayed horizontal sync, active low |
| vs_out_n | output | 1 | Delayed vertical sync, active low |
| y_oe | output | 1 | Drive enable for the Y pads |
| c_oe | output | 1 | Drive enable for the C pads |
| hs_oe | output | 1 | Drive enable for the horizontal sync pad |
| vs_oe | output | 1 | Drive enable for the vertical sync pad |
| prio_out_n | output | 1 | Priority to lower devices; low means bus taken |

## Verification
The hardest situation to reach from the ports is a run whose length is not a multiple of the 4:1:1 group. Here the formatter must drop a half-used group and restart cleanly on the next run, while the chroma inputs carry misleading values on every non-first pixel.

The stimulus table drives runs of six pixels. Deliberately wrong (inverted) chroma is presented on the pixels that must be ignored. Each line follows the previous one, so a stale slot counter or stale held chroma would corrupt the first pixel of the next line.

The luma and chroma phase codes differ within one line, so the two paths are checked at different latencies in the same run. Every combination of the six enable inputs is swept.

// File: rtl/vof_pkg.sv
package vof_pkg;
  localparam int unsigned VOF_DW    = 8;
  localparam int unsigned VOF_PHW   = 2;
  localparam int unsigned VOF_DEPTH = 3;

  localparam logic [VOF_DW-1:0] VOF_BLANK_Y = 8'h10;
  localparam logic [VOF_DW-1:0] VOF_BLANK_C = 8'h80;
  localparam logic [VOF_DW-1:0] VOF_BLUE_Y  = 8'h29;
  localparam logic [VOF_DW-1:0] VOF_BLUE_CB = 8'hF0;
  localparam logic [VOF_DW-1:0] VOF_BLUE_CR = 8'h6E;

  typedef enum logic [VOF_PHW-1:0] {
    PH_NORM  = 2'd0,
    PH_EARLY = 2'd1,
    PH_RSVD  = 2'd2,
    PH_LATE  = 2'd3
  } vof_phase_e;

  // Chroma encoding: two's complement differs from offset binary in the MSB.
  function automatic logic [VOF_DW-1:0] vof_encode(input logic [VOF_DW-1:0] v,
                                                   input logic twos);
    return {v[VOF_DW-1] ^ twos, v[VOF_DW-2:0]};
  endfunction

  // 4:1:1 slot packing: two Cb bits then two Cr bits, MSB pair first.
  function automatic logic [VOF_DW-1:0] vof_pack411(input logic [VOF_DW-1:0] cb,
                                                    input logic [VOF_DW-1:0] cr,
                                                    input logic [1:0] slot);
    logic [VOF_DW-1:0] r;
    case (slot)
      2'd0:    r = {cb[7:6], cr[7:6], 4'h0};
      2'd1:    r = {cb[5:4], cr[5:4], 4'h0};
      2'd2:    r = {cb[3:2], cr[3:2], 4'h0};
      default: r = {cb[1:0], cr[1:0], 4'h0};
    endcase
    return r;
  endfunction

  // Phase code to pipeline tap: early=0, late=2, normal and reserved=1.
  function automatic logic [1:0] vof_tap(input logic [VOF_PHW-1:0] ph);
    logic [1:0] t;
    case (vof_phase_e'(ph))
      PH_EARLY: t = 2'd0;
      PH_LATE:  t = 2'd2;
      default:  t = 2'd1;
    endcase
    return t;
  endfunction
endpackage

// File: rtl/vof_pack.sv
module vof_pack
  import vof_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_vld,
  input  logic [VOF_DW-1:0] y_in,
  input  logic [VOF_DW-1:0] cb_in,
  input  logic [VOF_DW-1:0] cr_in,
  input  logic              sync_lock,
  input  logic              cfg_411,
  input  logic              cfg_twos,
  input  logic              cfg_blue_en,
  output logic [VOF_DW-1:0] fmt_y,
  output logic [VOF_DW-1:0] fmt_c
);
  logic [1:0]        slot;
  logic [VOF_DW-1:0] cb_h, cr_h;
  logic [VOF_DW-1:0] y_src, cb_src, cr_src;
  logic [VOF_DW-1:0] cb_sel, cr_sel, cb_enc, cr_enc;
  logic [VOF_DW-1:0] y_next, c_next;
  logic              blue_now, grp_first;

  always_comb begin
    blue_now  = cfg_blue_en & ~sync_lock;
    y_src     = blue_now ? VOF_BLUE_Y  : y_in;
    cb_src    = blue_now ? VOF_BLUE_CB : cb_in;
    cr_src    = blue_now ? VOF_BLUE_CR : cr_in;
    grp_first = cfg_411 ? (slot == 2'd0) : ~slot[0];
    cb_sel    = grp_first ? cb_src : cb_h;
    cr_sel    = grp_first ? cr_src : cr_h;
    cb_enc    = vof_encode(cb_sel, cfg_twos);
    cr_enc    = vof_encode(cr_sel, cfg_twos);
    if (!pix_vld) begin
      y_next = VOF_BLANK_Y;
      c_next = vof_encode(VOF_BLANK_C, cfg_twos);
    end else begin
      y_next = y_src;
      if (cfg_411) c_next = vof_pack411(cb_enc, cr_enc, slot);
      else         c_next = slot[0] ? cr_enc : cb_enc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot  <= 2'd0;
      cb_h  <= '0;
      cr_h  <= '0;
      fmt_y <= VOF_BLANK_Y;
      fmt_c <= VOF_BLANK_C;
    end else begin
      slot  <= pix_vld ? slot + 2'd1 : 2'd0;
      if (pix_vld && grp_first) begin
        cb_h <= cb_src;
        cr_h <= cr_src;
      end
      fmt_y <= y_next;
      fmt_c <= c_next;
    end
  end
endmodule

// File: rtl/vof_phase.sv
module vof_phase
  import vof_pkg::*;
#(
  parameter int unsigned W       = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [VOF_PHW-1:0] sel,
  input  logic [W-1:0]       d,
  output logic [W-1:0]       q
);
  localparam int unsigned NREG = VOF_DEPTH - 1;

  logic [NREG:1][W-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 1; i <= NREG; i++) pipe[i] <= RST_VAL;
    end else begin
      pipe[1] <= d;
      for (int i = 2; i <= NREG; i++) pipe[i] <= pipe[i-1];
    end
  end

  always_comb begin
    case (vof_tap(sel))
      2'd0:    q = d;
      2'd2:    q = pipe[NREG];
      default: q = pipe[1];
    endcase
  end
endmodule

// File: rtl/vof_busctl.sv
module vof_busctl #(
  parameter int unsigned NBUS = 4
) (
  input  logic [NBUS-1:0] bus_en,
  input  logic            oe_n,
  input  logic            prio_in_n,
  output logic [NBUS-1:0] bus_oe,
  output logic            prio_out_n
);
  for (genvar g = 0; g < NBUS; g++) begin : g_lane
    assign bus_oe[g] = ~oe_n & bus_en[g] & prio_in_n;
  end
  assign prio_out_n = prio_in_n & ~(|bus_oe);
endmodule

// File: rtl/vid_out_fmt.sv
module vid_out_fmt
  import vof_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pix_vld,
  input  logic [VOF_DW-1:0]  y_in,
  input  logic [VOF_DW-1:0]  cb_in,
  input  logic [VOF_DW-1:0]  cr_in,
  input  logic               hs_in_n,
  input  logic               vs_in_n,
  input  logic               sync_lock,
  input  logic               cfg_411,
  input  logic               cfg_twos,
  input  logic               cfg_blue_en,
  input  logic [VOF_PHW-1:0] y_phase,
  input  logic [VOF_PHW-1:0] c_phase,
  input  logic               en_y,
  input  logic               en_c,
  input  logic               en_hs,
  input  logic               en_vs,
  input  logic               oe_n,
  input  logic               prio_in_n,
  output logic [VOF_DW-1:0]  y_out,
  output logic [VOF_DW-1:0]  c_out,
  output logic               hs_out_n,
  output logic               vs_out_n,
  output logic               y_oe,
  output logic               c_oe,
  output logic               hs_oe,
  output logic               vs_oe,
  output logic               prio_out_n
);
  localparam int unsigned NBUS = 4;

  logic [VOF_DW-1:0] fmt_y, fmt_c;
  logic [1:0]        sync_q, sync_d;
  logic [NBUS-1:0]   bus_oe;

  vof_pack u_pack (
    .clk(clk), .rst_n(rst_n), .pix_vld(pix_vld),
    .y_in(y_in), .cb_in(cb_in), .cr_in(cr_in),
    .sync_lock(sync_lock), .cfg_411(cfg_411), .cfg_twos(cfg_twos),
    .cfg_blue_en(cfg_blue_en), .fmt_y(fmt_y), .fmt_c(fmt_c)
  );

  vof_phase #(.W(VOF_DW), .RST_VAL(VOF_BLANK_Y)) u_yph (
    .clk(clk), .rst_n(rst_n), .sel(y_phase), .d(fmt_y), .q(y_out)
  );

  vof_phase #(.W(VOF_DW), .RST_VAL(VOF_BLANK_C)) u_cph (
    .clk(clk), .rst_n(rst_n), .sel(c_phase), .d(fmt_c), .q(c_out)
  );

  // Syncs take the formatter stage plus the normal tap: two clocks.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {hs_in_n, vs_in_n};
  end

  vof_phase #(.W(2), .RST_VAL(2'b11)) u_sph (
    .clk(clk), .rst_n(rst_n), .sel(PH_NORM), .d(sync_q), .q(sync_d)
  );
  assign hs_out_n = sync_d[1];
  assign vs_out_n = sync_d[0];

  vof_busctl #(.NBUS(NBUS)) u_bus (
    .bus_en({en_vs, en_hs, en_c, en_y}), .oe_n(oe_n), .prio_in_n(prio_in_n),
    .bus_oe(bus_oe), .prio_out_n(prio_out_n)
  );
  assign y_oe  = bus_oe[0];
  assign c_oe  = bus_oe[1];
  assign hs_oe = bus_oe[2];
  assign vs_oe = bus_oe[3];
endmodule

// File: rtl/vid_out_fmt_chk.sv
module vid_out_fmt_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pix_vld,
  input logic [7:0] y_in,
  input logic       sync_lock,
  input logic       cfg_blue_en,
  input logic       cfg_411,
  input logic [1:0] y_phase,
  input logic       hs_in_n,
  input logic       hs_out_n,
  input logic [7:0] y_out,
  input logic [7:0] c_out,
  input logic       prio_in_n,
  input logic       prio_out_n,
  input logic       y_oe,
  input logic       c_oe,
  input logic       hs_oe,
  input logic       vs_oe
);
  // R9
  prio_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !prio_in_n |-> !(y_oe | c_oe | hs_oe | vs_oe));

  // R10
  prio_out_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (y_oe | c_oe | hs_oe | vs_oe) |-> !prio_out_n);

  // R10
  prio_out_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prio_in_n && !(y_oe | c_oe | hs_oe | vs_oe)) |-> prio_out_n);

  // R3
  nibble_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_411 |-> (c_out[3:0] == 4'h0));

  // R6
  luma_norm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_vld && !(cfg_blue_en && !sync_lock) && y_phase == 2'd0)
      |=> ##1 (y_out == $past(y_in, 2)));

  // R5
  blue_luma_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_vld && cfg_blue_en && !sync_lock && y_phase == 2'd1)
      |=> (y_out == 8'h29));

  // R8
  sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n, 2) |-> (hs_out_n == $past(hs_in_n, 2)));
endmodule

bind vid_out_fmt vid_out_fmt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pix_vld(pix_vld), .y_in(y_in),
  .sync_lock(sync_lock), .cfg_blue_en(cfg_blue_en), .cfg_411(cfg_411),
  .y_phase(y_phase), .hs_in_n(hs_in_n), .hs_out_n(hs_out_n),
  .y_out(y_out), .c_out(c_out), .prio_in_n(prio_in_n),
  .prio_out_n(prio_out_n), .y_oe(y_oe), .c_oe(c_oe), .hs_oe(hs_oe),
  .vs_oe(vs_oe)
);

// File: tb/vid_out_fmt_bench.sv
`timescale 1ns/1ps
module vid_out_fmt_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NPIX = 6;
  localparam int NENT = 8;
  // {m411, twos, blue_en, lock, yph[2], cph[2], seed[8], expected C of pixel 0[8]}
  localparam logic [23:0] TBL [NENT] = '{
    {1'b0, 1'b0, 1'b1, 1'b1, 2'd0, 2'd0, 8'h10, 8'h50},
    {1'b0, 1'b1, 1'b1, 1'b1, 2'd1, 2'd1, 8'h20, 8'hE0},
    {1'b1, 1'b0, 1'b1, 1'b1, 2'd0, 2'd0, 8'h30, 8'h70},
    {1'b1, 1'b1, 1'b1, 1'b1, 2'd3, 2'd3, 8'h05, 8'hC0},
    {1'b0, 1'b0, 1'b1, 1'b0, 2'd1, 2'd3, 8'h77, 8'hF0},
    {1'b1, 1'b0, 1'b1, 1'b0, 2'd2, 2'd1, 8'h11, 8'hD0},
    {1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 2'd1, 8'hA0, 8'hE0},
    {1'b1, 1'b1, 1'b0, 1'b1, 2'd1, 2'd0, 8'hC8, 8'hB0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pix_vld = 1'b0;
  logic [7:0] y_in = '0, cb_in = '0, cr_in = '0;
  logic hs_in_n = 1'b1, vs_in_n = 1'b1, sync_lock = 1'b1;
  logic cfg_411 = 1'b0, cfg_twos = 1'b0, cfg_blue_en = 1'b1;
  logic [1:0] y_phase = 2'd0, c_phase = 2'd0;
  logic en_y = 1'b1, en_c = 1'b1, en_hs = 1'b1, en_vs = 1'b1;
  logic oe_n = 1'b0, prio_in_n = 1'b1;
  logic [7:0] y_out, c_out;
  logic hs_out_n, vs_out_n, y_oe, c_oe, hs_oe, vs_oe, prio_out_n;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [7:0] seed;

  always #(CLK_PERIOD/2) clk = ~clk;

  vid_out_fmt u_vid_out_fmt (
    .clk(clk), .rst_n(rst_n), .pix_vld(pix_vld), .y_in(y_in), .cb_in(cb_in),
    .cr_in(cr_in), .hs_in_n(hs_in_n), .vs_in_n(vs_in_n), .sync_lock(sync_lock),
    .cfg_411(cfg_411), .cfg_twos(cfg_twos), .cfg_blue_en(cfg_blue_en),
    .y_phase(y_phase), .c_phase(c_phase), .en_y(en_y), .en_c(en_c),
    .en_hs(en_hs), .en_vs(en_vs), .oe_n(oe_n), .prio_in_n(prio_in_n),
    .y_out(y_out), .c_out(c_out), .hs_out_n(hs_out_n), .vs_out_n(vs_out_n),
    .y_oe(y_oe), .c_oe(c_oe), .hs_oe(hs_oe), .vs_oe(vs_oe),
    .prio_out_n(prio_out_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int lat(input logic [1:0] ph);
    if (ph == 2'd1) return 1;
    if (ph == 2'd3) return 3;
    return 2;
  endfunction

  function automatic bit blue_on();
    return cfg_blue_en && !sync_lock;
  endfunction

  function automatic logic [7:0] grp_cb(input int i);
    int g = cfg_411 ? i / 4 : i / 2;
    return seed + 8'h40 + 8'(7 * g);
  endfunction

  function automatic logic [7:0] grp_cr(input int i);
    int g = cfg_411 ? i / 4 : i / 2;
    return seed + 8'h90 - 8'(5 * g);
  endfunction

  function automatic logic [7:0] exp_y(input int i);
    return blue_on() ? 8'h29 : seed + 8'(5 * i);
  endfunction

  function automatic logic [7:0] exp_c(input int i);
    logic [7:0] cb = blue_on() ? 8'hF0 : grp_cb(i);
    logic [7:0] cr = blue_on() ? 8'h6E : grp_cr(i);
    int s = i % 4;
    if (cfg_twos) begin
      cb = cb + 8'h80;
      cr = cr + 8'h80;
    end
    if (cfg_411)
      return (((cb >> (6 - 2 * s)) & 8'h3) << 6) | (((cr >> (6 - 2 * s)) & 8'h3) << 4);
    return (i % 2 == 1) ? cr : cb;
  endfunction

  task automatic run_entry(input int e);
    logic [23:0] v;
    int ly, lc;
    bit first;
    v = TBL[e];
    {cfg_411, cfg_twos, cfg_blue_en, sync_lock, y_phase, c_phase} = v[23:16];
    seed = v[15:8];
    ly = lat(y_phase);
    lc = lat(c_phase);
    repeat (4) @(negedge clk);
    for (int t = 0; t < NPIX + 4; t++) begin
      @(negedge clk);
      if (t - ly >= 0 && t - ly < NPIX)
        chk(y_out == exp_y(t - ly), blue_on() ? "R5 luma" : "R6 luma",
            y_out, exp_y(t - ly));
      if (t - lc == 0)
        chk(c_out == v[7:0], "R11 R4 first chroma", c_out, v[7:0]);
      else if (t - lc > 0 && t - lc < NPIX)
        chk(c_out == exp_c(t - lc), cfg_411 ? "R3 chroma" : "R2 chroma",
            c_out, exp_c(t - lc));
      if (t < NPIX) begin
        first = cfg_411 ? (t % 4 == 0) : (t % 2 == 0);
        pix_vld = 1'b1;
        y_in = seed + 8'(5 * t);
        cb_in = first ? grp_cb(t) : ~grp_cb(t);
        cr_in = first ? grp_cr(t) : ~grp_cr(t);
      end else begin
        pix_vld = 1'b0;
        y_in = 8'hEE;
        cb_in = 8'h33;
        cr_in = 8'hCC;
      end
    end
    repeat (2) @(negedge clk);
    chk(y_out == 8'h10, "R7 blank luma", y_out, 8'h10);
    chk(c_out == (cfg_twos ? 8'h00 : 8'h80), "R7 blank chroma", c_out,
        cfg_twos ? 8'h00 : 8'h80);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [5:0] k;
    logic [3:0] eo;
    repeat (3) @(negedge clk);
    chk(y_out == 8'h10, "R1 reset luma", y_out, 8'h10);
    chk(c_out == 8'h80, "R1 reset chroma", c_out, 8'h80);
    rst_n = 1'b1;
    @(negedge clk);
    chk(y_out == 8'h10, "R1 luma after release", y_out, 8'h10);
    chk(c_out == 8'h80, "R1 chroma after release", c_out, 8'h80);
    chk({hs_out_n, vs_out_n} == 2'b11, "R1 syncs idle", {hs_out_n, vs_out_n}, 3);

    for (int e = 0; e < NENT; e++) run_entry(e);

    // R8: sync pulses come out two clocks later
    @(negedge clk);
    hs_in_n = 1'b0;
    @(negedge clk);
    hs_in_n = 1'b1;
    vs_in_n = 1'b0;
    chk(hs_out_n == 1'b1, "R8 hs before", hs_out_n, 1);
    @(negedge clk);
    vs_in_n = 1'b1;
    chk(hs_out_n == 1'b0, "R8 hs delayed", hs_out_n, 0);
    chk(vs_out_n == 1'b1, "R8 vs before", vs_out_n, 1);
    @(negedge clk);
    chk(hs_out_n == 1'b1, "R8 hs released", hs_out_n, 1);
    chk(vs_out_n == 1'b0, "R8 vs delayed", vs_out_n, 0);
    @(negedge clk);
    chk(vs_out_n == 1'b1, "R8 vs released", vs_out_n, 1);

    // R9 R10: every combination of pin, priority and register enables
    for (int n = 0; n < 64; n++) begin
      k = 6'(n);
      {oe_n, prio_in_n, en_y, en_c, en_hs, en_vs} = k;
      #1;
      eo = (!k[5] && k[4]) ? {k[0], k[1], k[2], k[3]} : 4'h0;
      chk({vs_oe, hs_oe, c_oe, y_oe} == eo, "R9 enables",
          {vs_oe, hs_oe, c_oe, y_oe}, eo);
      chk(prio_out_n == (k[4] && eo == 4'h0), "R10 priority out",
          prio_out_n, (k[4] && eo == 4'h0));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule